// File: doc/BRIEF.md
# Lockable SMM Window Control Register

This block holds one 8-bit configuration register that decides how a small, fixed RAM window behaves. Firmware first writes a query code. The register answers with an acknowledge code, and from then on only the lock bit can be written. Firmware then sets the lock bit, and the lock cannot be undone. While the register is locked, an access that falls inside the window from outside system-management mode is sent to a blackhole, which reads all ones and drops writes. An access from system-management mode is steered to RAM. Any write made before the query is discarded.

A build-time feature switch can turn the mechanism off. The register then stores what is written, and the window select outputs never assert. Window decoding is combinational from the access address, the mode flag and the lock state. Register updates take effect on the clock edge after the write strobe.

Top module: `smbase_lock_reg`

## Requirements
- R1: After reset the register reads 0x00, the whole register is writable in the mask sense, the register is unlocked and both select outputs are low.
- R2: A write forms its candidate value from the current mask: bits set in the mask take the written data and the other bits keep their stored value. With the feature on, only the lock bit (bit LOCK_BIT, default bit 0) is writable after a query.
- R3: With the feature on, a write whose candidate equals the query code (default 0xFF) loads the acknowledge code (default 0x01), reduces the mask to the lock bit and leaves the register unlocked. The select outputs stay low.
- R4: With the feature on, a non-query write made while the mask is still all ones forces the register to 0x00. This includes a write that has the lock bit set, and such a write does not lock.
- R5: After a query, a write whose candidate has the lock bit set locks the register, which then reads the lock bit alone (0x01 by default).
- R6: After a query, a write whose candidate has the lock bit clear stores the candidate and leaves the register unlocked.
- R7: Once locked, the register stays locked and keeps reading the lock bit alone, whatever is written, until reset.
- R8: blackholeSel is high exactly when the register is locked, the address hits the window and accSmm is low.
- R9: smmWinSel is high exactly when the register is locked, the address hits the window and accSmm is high. The two selects are never high together.
- R10: An address hits the window when WIN_BASE <= accAddr < WIN_BASE + WIN_SIZE. Both the first and the last address are inside; the addresses just below and just past the window are outside.
- R11: With FEAT_EN = 0, each write stores the data as written (the mask stays all ones), the query and lock rules do not apply, and both selects stay low.
- R12: Reset returns a locked register to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Current register value |
| accAddr | input | ADDR_W | Address of the access being decoded |
| accSmm | input | 1 | Access comes from system-management mode |
| blackholeSel | output | 1 | Route the access to the all-ones/write-drop sink |
| smmWinSel | output | 1 | Route the access to RAM in the window |

## Verification
The bench builds two copies of the block side by side, one with FEAT_EN = 1 and one with FEAT_EN = 0, and drives both from the same stimulus. A single write sequence therefore shows the query, discard and lock rules on one copy and the plain-storage behaviour on the other. A 20-bit address with a window that ends at 0x40000 makes it cheap to probe the addresses just below, at, and just past both edges of the window. The query, acknowledge and lock-bit parameters keep their defaults, so the acknowledge code shares its bit with the lock bit. This exercises the case where the register reads the lock bit before it is actually locked.

// File: rtl/smbase_lock_pkg.sv
package smbase_lock_pkg;

  // One-hot update command passed from control to datapath on a write
  typedef struct packed {
    logic store;  // load the masked candidate value
    logic ack;    // load acknowledge code, narrow mask to lock bit
    logic clear;  // force register to zero
    logic lock;   // enter locked state
  } regStrobe_t;

endpackage

// File: rtl/smbase_lock_ctrl.sv
module smbase_lock_ctrl
  import smbase_lock_pkg::*;
#(
  parameter bit         FEAT_EN    = 1'b1,
  parameter logic [7:0] QUERY_CODE = 8'hFF,
  parameter int         LOCK_BIT   = 0
) (
  input  logic       wrEn,
  input  logic [7:0] candVal,
  input  logic [7:0] maskQ,
  output regStrobe_t strobe
);

  logic maskFull;
  assign maskFull = (maskQ == 8'hFF);

  generate
    if (FEAT_EN) begin : g_feat
      always_comb begin
        strobe = '0;
        if (wrEn) begin
          if (candVal == QUERY_CODE)   strobe.ack   = 1'b1;
          else if (maskFull)           strobe.clear = 1'b1;
          else if (candVal[LOCK_BIT])  strobe.lock  = 1'b1;
          else                         strobe.store = 1'b1;
        end
      end
    end else begin : g_plain
      always_comb begin
        strobe       = '0;
        strobe.store = wrEn;
      end
    end
  endgenerate

endmodule

// File: rtl/smbase_lock_dp.sv
module smbase_lock_dp
  import smbase_lock_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0001_0000,
  parameter logic [7:0]        ACK_CODE = 8'h01,
  parameter int                LOCK_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        wrData,
  input  regStrobe_t        strobe,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [7:0]        candVal,
  output logic [7:0]        maskQ,
  output logic [7:0]        regQ,
  output logic              lockedQ,
  output logic              winHit
);

  localparam logic [7:0]    LOCK_MASK = 8'(1) << LOCK_BIT;
  localparam logic [ADDR_W:0] WIN_LO  = {1'b0, WIN_BASE};
  localparam logic [ADDR_W:0] WIN_HI  = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

  logic [ADDR_W:0] addrExt;

  assign candVal = (regQ & ~maskQ) | (wrData & maskQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      regQ    <= 8'h00;
      maskQ   <= 8'hFF;
      lockedQ <= 1'b0;
    end else begin
      if (strobe.store) regQ <= candVal;
      if (strobe.clear) regQ <= 8'h00;
      if (strobe.ack) begin
        regQ  <= ACK_CODE;
        maskQ <= LOCK_MASK;
      end
      if (strobe.lock) begin
        regQ    <= LOCK_MASK;
        maskQ   <= maskQ & ~LOCK_MASK;
        lockedQ <= 1'b1;
      end
    end
  end

  assign addrExt = {1'b0, accAddr};
  assign winHit  = (addrExt >= WIN_LO) && (addrExt < WIN_HI);

endmodule

// File: rtl/smbase_lock_reg.sv
module smbase_lock_reg
  import smbase_lock_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE   = 32'h0001_0000,
  parameter bit                FEAT_EN    = 1'b1,
  parameter logic [7:0]        QUERY_CODE = 8'hFF,
  parameter logic [7:0]        ACK_CODE   = 8'h01,
  parameter int                LOCK_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSmm,
  output logic              blackholeSel,
  output logic              smmWinSel
);

  regStrobe_t strobe;
  logic [7:0] candVal;
  logic [7:0] maskQ;
  logic       lockedQ;
  logic       winHit;

  smbase_lock_ctrl #(
    .FEAT_EN(FEAT_EN), .QUERY_CODE(QUERY_CODE), .LOCK_BIT(LOCK_BIT)
  ) u_ctrl (
    .wrEn(wrEn), .candVal(candVal), .maskQ(maskQ), .strobe(strobe)
  );

  smbase_lock_dp #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
    .ACK_CODE(ACK_CODE), .LOCK_BIT(LOCK_BIT)
  ) u_dp (
    .clk(clk), .rst(rst), .wrData(wrData), .strobe(strobe),
    .accAddr(accAddr), .candVal(candVal), .maskQ(maskQ),
    .regQ(rdData), .lockedQ(lockedQ), .winHit(winHit)
  );

  assign blackholeSel = lockedQ & winHit & ~accSmm;
  assign smmWinSel    = lockedQ & winHit &  accSmm;

endmodule

// File: rtl/smbase_lock_chk.sv
module smbase_lock_chk #(
  parameter bit FEAT_EN  = 1'b1,
  parameter int LOCK_BIT = 0
) (
  input logic       clk,
  input logic       rst,
  input logic       lockedQ,
  input logic [7:0] rdData,
  input logic       accSmm,
  input logic       blackholeSel,
  input logic       smmWinSel
);

  localparam logic [7:0] LOCK_MASK = 8'(1) << LOCK_BIT;

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rdData == 8'h00 && !lockedQ));

  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lockedQ |=> lockedQ);

  a_r7_locked_value: assert property (@(posedge clk) disable iff (rst)
    lockedQ |=> (rdData == LOCK_MASK));

  a_r8_blackhole_cond: assert property (@(posedge clk) disable iff (rst)
    blackholeSel |-> (lockedQ && !accSmm));

  a_r9_smm_cond: assert property (@(posedge clk) disable iff (rst)
    smmWinSel |-> (lockedQ && accSmm));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({blackholeSel, smmWinSel}));

  generate
    if (!FEAT_EN) begin : g_off
      a_r11_never_locks: assert property (@(posedge clk) disable iff (rst)
        !lockedQ);
    end
  endgenerate

endmodule

bind smbase_lock_reg smbase_lock_chk #(.FEAT_EN(FEAT_EN), .LOCK_BIT(LOCK_BIT)) u_chk (
  .clk(clk), .rst(rst), .lockedQ(lockedQ), .rdData(rdData),
  .accSmm(accSmm), .blackholeSel(blackholeSel), .smmWinSel(smmWinSel)
);

// File: tb/smbase_lock_reg_bench.sv
`timescale 1ns/1ps
module smbase_lock_reg_bench;

  localparam int          AW    = 20;
  localparam logic [19:0] BASE  = 20'h38000;
  localparam logic [19:0] SIZE  = 20'h08000;
  localparam int          QUERY = 8'hFF;
  localparam int          ACK   = 8'h01;
  localparam int          LOCKM = 8'h01;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic [7:0]    wrData = 8'h00;
  logic [AW-1:0] accAddr = BASE;
  logic          accSmm = 1'b0;

  logic [7:0] rdOn, rdOff;
  logic       bhOn, bhOff, smOn, smOff;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, index 0: feature on, 1: feature off
  int mReg[2];
  int mMask[2];
  bit mLock[2];

  always #2.5 clk = ~clk;

  smbase_lock_reg #(.ADDR_W(AW), .WIN_BASE(BASE), .WIN_SIZE(SIZE), .FEAT_EN(1'b1))
    u_smbase_lock_reg (.clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdData(rdOn),
      .accAddr(accAddr), .accSmm(accSmm), .blackholeSel(bhOn), .smmWinSel(smOn));

  smbase_lock_reg #(.ADDR_W(AW), .WIN_BASE(BASE), .WIN_SIZE(SIZE), .FEAT_EN(1'b0))
    u_smbase_lock_reg_off (.clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdData(rdOff),
      .accAddr(accAddr), .accSmm(accSmm), .blackholeSel(bhOff), .smmWinSel(smOff));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model updated at every clock edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        mReg[i] = 0; mMask[i] = 'hFF; mLock[i] = 0;
      end
    end else if (wrEn) begin
      for (int i = 0; i < 2; i++) begin
        int cand;
        cand = ((mReg[i] & ~mMask[i]) | (int'(wrData) & mMask[i])) & 'hFF;
        if (i == 1) mReg[i] = cand;
        else if (cand == QUERY) begin mReg[i] = ACK; mMask[i] = LOCKM; end
        else if (mMask[i] == 'hFF) mReg[i] = 0;
        else if ((cand & LOCKM) != 0) begin
          mReg[i] = LOCKM; mMask[i] = mMask[i] & ~LOCKM & 'hFF; mLock[i] = 1;
        end
        else mReg[i] = cand;
      end
    end
  end

  function automatic bit hitNow();
    return (int'(accAddr) >= int'(BASE)) && (int'(accAddr) < int'(BASE) + int'(SIZE));
  endfunction

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(rdOn == 8'(mReg[0]), "R2 model rdData(on)", rdOn, mReg[0]);
      check(rdOff == 8'(mReg[1]), "R11 model rdData(off)", rdOff, mReg[1]);
      check(bhOn == (mLock[0] && hitNow() && !accSmm), "R8 model blackholeSel", bhOn,
            mLock[0] && hitNow() && !accSmm);
      check(smOn == (mLock[0] && hitNow() && accSmm), "R9 model smmWinSel", smOn,
            mLock[0] && hitNow() && accSmm);
      check(!bhOff && !smOff, "R11 model selects(off)", {bhOff, smOff}, 0);
    end
  end

  task automatic doWrite(input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    #0.5;
  endtask

  task automatic setAcc(input logic [AW-1:0] a, input logic s);
    @(negedge clk); accAddr = a; accSmm = s;
    #0.5;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk); #0.5;
  endtask

  initial begin
    doReset();
    check(rdOn == 8'h00, "R1 reset value", rdOn, 8'h00);
    check(!bhOn && !smOn, "R1 reset selects", {bhOn, smOn}, 0);

    doWrite(8'h5A);
    check(rdOn == 8'h00, "R4 pre-query write discarded", rdOn, 8'h00);
    check(rdOff == 8'h5A, "R11 plain store", rdOff, 8'h5A);
    doWrite(8'h01);
    check(rdOn == 8'h00, "R4 early lock discarded", rdOn, 8'h00);
    check(!bhOn, "R4 no lock before query", bhOn, 0);

    doWrite(8'hFF);
    check(rdOn == 8'h01, "R3 query acknowledged", rdOn, 8'h01);
    check(!bhOn && !smOn, "R3 selects low after query", {bhOn, smOn}, 0);
    check(rdOff == 8'hFF, "R11 query stored plainly", rdOff, 8'hFF);

    doWrite(8'hFE);
    check(rdOn == 8'h00, "R6 unlocked masked store", rdOn, 8'h00);
    check(!bhOn, "R6 still unlocked", bhOn, 0);
    doWrite(8'hF0);
    check(rdOn == 8'h00, "R2 bits outside mask ignored", rdOn, 8'h00);

    doWrite(8'h03);
    check(rdOn == 8'h01, "R5 locked value", rdOn, 8'h01);
    check(bhOn && !smOn, "R8 blackhole when locked non-SMM", {bhOn, smOn}, 2'b10);
    check(!bhOff && rdOff == 8'h03, "R11 off copy unaffected", {bhOff, rdOff}, 8'h03);

    setAcc(BASE, 1'b1);
    check(smOn && !bhOn, "R9 SMM reaches RAM", {bhOn, smOn}, 2'b01);

    setAcc(BASE - 20'd1, 1'b0);
    check(!bhOn, "R10 below window", bhOn, 0);
    setAcc(BASE + SIZE - 20'd1, 1'b0);
    check(bhOn, "R10 last address inside", bhOn, 1);
    setAcc(BASE + SIZE, 1'b0);
    check(!bhOn, "R10 past window", bhOn, 0);
    setAcc(BASE, 1'b0);
    check(bhOn, "R10 first address inside", bhOn, 1);

    doWrite(8'h00);
    check(rdOn == 8'h01 && bhOn, "R7 lock survives clear write", {bhOn, rdOn}, 9'h101);
    doWrite(8'hFF);
    check(rdOn == 8'h01 && bhOn, "R7 lock survives query write", {bhOn, rdOn}, 9'h101);

    doReset();
    check(rdOn == 8'h00 && !bhOn, "R12 reset unlocks", {bhOn, rdOn}, 0);
    doWrite(8'hFF);
    doWrite(8'h01);
    check(rdOn == 8'h01 && bhOn, "R5 relock after reset", {bhOn, rdOn}, 9'h101);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule